// File: doc/BRIEF.md
# Programmable Undervoltage Reset Sequencer

This block produces the active-low reset line of a microcontroller from the digitized outputs of a power supervisor. Each monitored supply rail provides a single "rail is good" comparator bit. The block filters every one of these bits. It holds reset low while any rail is out of range. Once all rails are back, it keeps reset low for a programmable release delay before letting it go. A short dip that passes the filter therefore still costs the full delay, so the reset pulse is never shorter than the programmed time.

The delay is chosen by a 2-bit code that the serial interface loads with a one-cycle write strobe. The block also decides whether that code survives a sleep or power-off period. A separate comparator bit reports whether the main rail stayed above its retention level. If that bit drops at any point while the sleep input is high, a sticky "settings lost" flag is set. On wake-up, the flag makes the code return to its default of 8 ms, and the flag then clears. If the main rail held, the last written code stays in effect.

There is no data stream here. The write port is a plain strobe that is always accepted in the cycle it is high, and it has no ready or back-pressure. All other pins are plain level signals. Timers and filters advance only on cycles where the `tick` timebase enable is high. One millisecond equals `TICKS_PER_MS` ticks.

Top module: `uvr_reset_delay`

## Requirements
- R1: While `rst_n` is low, `mcu_rst_n` is low and the delay code is reset to its default value 0 (8 ms).
- R2: Bit i of `rail_ok` is 1 when rail i is good. When any filtered rail bit is 0, `mcu_rst_n` goes low on the next clock edge and stays low.
- R3: Once all filtered rail bits are 1, `mcu_rst_n` rises after exactly L ticks, where L = 8·2^code·`TICKS_PER_MS`. It stays high while all rails remain good.
- R4: If any rail drops out while the release delay is running, the delay count restarts from zero after the rails recover.
- R5: Each `rail_ok` bit passes through a 2-flop synchronizer. A new level takes effect only after it has been seen on 4 consecutive ticks. A change lasting 3 cycles or less (with `tick` high) has no effect on `mcu_rst_n`.
- R6: A dip long enough to pass the filter produces a full release delay after recovery.
- R7: A cycle with `cfg_wr` high and `sleep` low loads `cfg_code`. The codes 0, 1, 2 and 3 select 8, 16, 32 and 64 ms.
- R8: `cfg_wr` is ignored while `sleep` is high.
- R9: If the synchronized `retain_ok` is low in any cycle while `sleep` is high, the code returns to the default 0 on the falling edge of `sleep`.
- R10: If `retain_ok` stays high for the whole sleep period, the code written before sleep is still in effect after wake-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | Timebase enable for the filter and the delay counter |
| rail_ok | input | N_RAILS | Per-rail comparator bits; 1 = rail above its reset threshold |
| retain_ok | input | 1 | Main rail above its retention level |
| sleep | input | 1 | High during a sleep or power-off period |
| cfg_wr | input | 1 | One-cycle load strobe from the serial interface |
| cfg_code | input | 2 | Delay code to load |
| mcu_rst_n | output | 1 | Reset to the microcontroller, active low |

## Verification
Take a rail change driven just after clock edge k, with `tick` held high. It reaches the filter output at edge k+6: two synchronizer edges and then four filtering edges. A fall therefore shows on `mcu_rst_n` at edge k+7, and a recovery releases reset at edge k+6+L. For each recovery, the driver queues the edge at which release is due. A monitor samples on falling clock edges and compares the edge count at each observed rise with the oldest queued entry. A rise that arrives early, arrives late or has no queued entry is a miscompare. Falls, filtered glitches and the absence of early releases are checked directly, at the falling edge just before and just after edge k+7.

// File: rtl/uvr_pkg.sv
package uvr_pkg;
  typedef logic [1:0] dly_code_t;

  localparam dly_code_t DLY_CODE_DEFAULT = 2'd0;

  // Release delay in ticks: 8 ms scaled by a power of two.
  function automatic int unsigned dly_ticks(dly_code_t code, int unsigned tpm);
    return (32'd8 << code) * tpm;
  endfunction
endpackage

// File: rtl/uvr_rail_filter.sv
module uvr_rail_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_TICKS   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw_ok,
  output logic ok_o
);
  localparam int DCW = $clog2(DEB_TICKS + 1);

  logic [SYNC_STAGES-1:0] sh;
  logic                   synced;
  logic [DCW-1:0]         cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-2:0], raw_ok};
  end

  assign synced = sh[SYNC_STAGES-1];

  // A new level must persist for DEB_TICKS ticks before it is accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_o <= 1'b0;
      cnt  <= '0;
    end else if (synced == ok_o) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == DCW'(DEB_TICKS - 1)) begin
        ok_o <= synced;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uvr_cfg_keep.sv
module uvr_cfg_keep
  import uvr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep,
  input  logic      retain_ok,
  input  logic      wr,
  input  dly_code_t wr_code,
  output dly_code_t code_o,
  output logic      lost_o,
  output logic      wake_o
);
  logic [SYNC_STAGES-1:0] ret_sh;
  logic                   ret_s;
  logic                   sleep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_sh  <= '1;
      sleep_q <= 1'b0;
    end else begin
      ret_sh  <= {ret_sh[SYNC_STAGES-2:0], retain_ok};
      sleep_q <= sleep;
    end
  end

  assign ret_s  = ret_sh[SYNC_STAGES-1];
  assign wake_o = sleep_q & ~sleep;

  // Sticky loss flag: set by a retention drop during sleep, cleared by the reload.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lost_o <= 1'b0;
    else if (wake_o)         lost_o <= 1'b0;
    else if (sleep && !ret_s) lost_o <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                code_o <= DLY_CODE_DEFAULT;
    else if (wake_o && lost_o) code_o <= DLY_CODE_DEFAULT;
    else if (wr && !sleep)     code_o <= wr_code;
  end
endmodule

// File: rtl/uvr_release_timer.sv
module uvr_release_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          all_ok,
  input  logic [CW-1:0] lim_m1,
  output logic          rst_n_o
);
  logic [CW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_n_o <= 1'b0;
      dcnt    <= '0;
    end else if (!all_ok) begin
      rst_n_o <= 1'b0;
      dcnt    <= '0;
    end else if (!rst_n_o && tick) begin
      if (dcnt >= lim_m1) begin
        rst_n_o <= 1'b1;
        dcnt    <= '0;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uvr_reset_delay.sv
module uvr_reset_delay
  import uvr_pkg::*;
#(
  parameter int N_RAILS      = 3,
  parameter int SYNC_STAGES  = 2,
  parameter int DEB_TICKS    = 4,
  parameter int TICKS_PER_MS = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [N_RAILS-1:0] rail_ok,
  input  logic               retain_ok,
  input  logic               sleep,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_code,
  output logic               mcu_rst_n
);
  localparam int CW = $clog2(64 * TICKS_PER_MS);

  logic [N_RAILS-1:0] rail_f;
  logic               all_ok;
  dly_code_t          dly_code;
  logic               cfg_lost;
  logic               wake;
  logic [CW-1:0]      lim_m1;

  for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
    uvr_rail_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .DEB_TICKS  (DEB_TICKS)
    ) filt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .raw_ok(rail_ok[i]),
      .ok_o  (rail_f[i])
    );
  end

  assign all_ok = &rail_f;

  uvr_cfg_keep #(
    .SYNC_STAGES(SYNC_STAGES)
  ) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .retain_ok(retain_ok),
    .wr       (cfg_wr),
    .wr_code  (cfg_code),
    .code_o   (dly_code),
    .lost_o   (cfg_lost),
    .wake_o   (wake)
  );

  always_comb lim_m1 = CW'(dly_ticks(dly_code, TICKS_PER_MS) - 32'd1);

  uvr_release_timer #(
    .CW(CW)
  ) tmr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .all_ok (all_ok),
    .lim_m1 (lim_m1),
    .rst_n_o(mcu_rst_n)
  );
endmodule

// File: rtl/uvr_reset_delay_chk.sv
module uvr_reset_delay_chk #(
  parameter int TICKS_PER_MS = 1000,
  parameter int CW           = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       all_ok,
  input logic       sleep,
  input logic       wake,
  input logic       cfg_lost,
  input logic       cfg_wr,
  input logic [1:0] code,
  input logic       mcu_rst_n
);
  logic [CW:0] ok_cnt;
  logic [CW:0] lim;

  always_comb begin
    case (code)
      2'd0:    lim = (CW+1)'(8 * TICKS_PER_MS);
      2'd1:    lim = (CW+1)'(16 * TICKS_PER_MS);
      2'd2:    lim = (CW+1)'(32 * TICKS_PER_MS);
      default: lim = (CW+1)'(64 * TICKS_PER_MS);
    endcase
  end

  // Consecutive good ticks since the rails last recovered, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ok_cnt <= '0;
    else if (!all_ok)              ok_cnt <= '0;
    else if (tick && !(&ok_cnt))   ok_cnt <= ok_cnt + 1'b1;
  end

  p_fault_holds_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !all_ok |=> !mcu_rst_n);

  p_stays_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_rst_n && all_ok) |=> mcu_rst_n);

  p_full_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mcu_rst_n) |-> (ok_cnt >= lim));

  p_sleep_freezes_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(code));

  p_lost_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && cfg_lost) |=> (code == 2'd0));

  p_kept_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !cfg_lost && !cfg_wr) |=> $stable(code));
endmodule

bind uvr_reset_delay uvr_reset_delay_chk #(
  .TICKS_PER_MS(TICKS_PER_MS),
  .CW          (CW)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .all_ok   (all_ok),
  .sleep    (sleep),
  .wake     (wake),
  .cfg_lost (cfg_lost),
  .cfg_wr   (cfg_wr),
  .code     (dly_code),
  .mcu_rst_n(mcu_rst_n)
);

// File: tb/uvr_reset_delay_tb_top.sv
module uvr_reset_delay_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR         = 3;
  localparam int TPM        = 2;
  localparam int WDOG       = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b1;
  logic [NR-1:0] rail_ok = '0;
  logic          retain_ok = 1'b1;
  logic          sleep = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_code = 2'd0;
  logic          mcu_rst_n;

  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  bit prev_out = 0;

  typedef struct { int due; string tag; } exp_t;
  exp_t q[$];

  uvr_reset_delay #(
    .N_RAILS     (NR),
    .SYNC_STAGES (2),
    .DEB_TICKS   (4),
    .TICKS_PER_MS(TPM)
  ) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .rail_ok  (rail_ok),
    .retain_ok(retain_ok),
    .sleep    (sleep),
    .cfg_wr   (cfg_wr),
    .cfg_code (cfg_code),
    .mcu_rst_n(mcu_rst_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lim(int c);
    return (8 << c) * TPM;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Called right after the rails are driven good at a falling edge.
  task automatic expect_release(int code, string tag);
    exp_t e;
    e.due = cyc + 6 + lim(code);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_release();
    for (int i = 0; i < 400 && q.size() != 0; i++) step(1);
    step(3);
  endtask

  task automatic write_code(logic [1:0] c);
    cfg_code = c;
    cfg_wr   = 1'b1;
    step(1);
    cfg_wr   = 1'b0;
  endtask

  // Monitor: compares every release edge with the oldest queued expectation.
  always @(negedge clk) begin
    if (rst_n && mcu_rst_n && !prev_out) begin
      if (q.size() == 0) begin
        chk(0, "R3 unexpected release", cyc, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.due, e.tag, cyc, e.due);
      end
    end
    prev_out = mcu_rst_n;
  end

  always @(posedge clk) begin
    if (!done && cyc > WDOG) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int k;
    // R1: reset state
    step(3);
    chk(mcu_rst_n == 1'b0, "R1 reset state", mcu_rst_n, 0);
    rst_n = 1'b1;
    step(4);
    chk(mcu_rst_n == 1'b0, "R1 held with rails down", mcu_rst_n, 0);

    // R1/R3: first release uses the default 8 ms code
    rail_ok = '1;
    expect_release(0, "R1/R3 default delay");
    wait_release();

    // R2: fall at edge k+7, not earlier
    rail_ok[1] = 1'b0;
    k = cyc;
    step(6);
    chk(mcu_rst_n == 1'b1, "R2 no early fall", mcu_rst_n, 1);
    step(1);
    chk(mcu_rst_n == 1'b0, "R2 fall after filter", mcu_rst_n, 0);
    step(5);
    // R6: full delay after a dip
    rail_ok[1] = 1'b1;
    expect_release(0, "R6 full delay after dip");
    wait_release();

    // R5: a 3-cycle glitch is filtered out
    rail_ok[0] = 1'b0;
    step(3);
    rail_ok[0] = 1'b1;
    for (int i = 0; i < 12; i++) begin
      step(1);
      chk(mcu_rst_n == 1'b1, "R5 glitch filtered", mcu_rst_n, 1);
    end

    // R7: code 1 selects 16 ms
    write_code(2'd1);
    rail_ok[2] = 1'b0;
    step(10);
    rail_ok[2] = 1'b1;
    expect_release(1, "R7 code 1");
    wait_release();

    // R4: drop-out during the running delay restarts the count
    rail_ok[0] = 1'b0;
    step(10);
    rail_ok[0] = 1'b1;
    step(20);
    chk(mcu_rst_n == 1'b0, "R4 still in delay", mcu_rst_n, 0);
    rail_ok[0] = 1'b0;
    step(10);
    rail_ok[0] = 1'b1;
    expect_release(1, "R4 restart");
    wait_release();

    // R8/R10: sleep with retention held, write during sleep ignored
    sleep = 1'b1;
    rail_ok = '0;
    step(10);
    write_code(2'd3);
    step(10);
    chk(mcu_rst_n == 1'b0, "R2 low during sleep", mcu_rst_n, 0);
    sleep = 1'b0;
    rail_ok = '1;
    expect_release(1, "R8/R10 code kept");
    wait_release();

    // R9: retention lost during sleep reloads the default
    sleep = 1'b1;
    rail_ok = '0;
    step(5);
    retain_ok = 1'b0;
    step(5);
    retain_ok = 1'b1;
    step(10);
    sleep = 1'b0;
    rail_ok = '1;
    expect_release(0, "R9 default reloaded");
    wait_release();

    // R7: codes 2 and 3
    write_code(2'd2);
    rail_ok[1] = 1'b0;
    step(8);
    rail_ok[1] = 1'b1;
    expect_release(2, "R7 code 2");
    wait_release();
    write_code(2'd3);
    rail_ok[2] = 1'b0;
    step(8);
    rail_ok[2] = 1'b1;
    expect_release(3, "R7 code 3");
    wait_release();

    chk(q.size() == 0, "R3 pending releases", q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule